// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Unit

This block watches every cycle on the CPU bus and raises a break request when an access meets a programmed condition. It has two channels, A and B. Each channel compares the bus address with a stored value. A per-bit mask removes address bits from that compare. The channel can also compare the address-space ID, or be set to ignore it. Each channel then qualifies the hit by access kind (instruction fetch or operand access) and by direction (read or write). Channel B can also require the operand data to equal a stored value, again under a bit mask.

The two channels work in one of two modes. In independent mode, either channel alone raises a break. In sequential mode, a channel A hit only arms the unit, and the break comes on a later cycle when channel B hits. Each channel has a sticky hit flag. The flag is set even when the CPU blocks exceptions, but in that case no request is issued. Software programs the unit through a simple register write/read port.

The register map, by `regAddr`, is:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | A address |
| 2 | A address mask |
| 3 | A ID |
| 4 | A cycle select |
| 5 | B address |
| 6 | B address mask |
| 7 | B ID |
| 8 | B cycle select |
| 9 | B data |
| 10 | B data mask |

Other addresses read as 0.

The control register bits are:
- bit 0: sequential mode
- bit 1: channel A pre-execution
- bit 2: channel B pre-execution
- bit 3: channel B data compare enable
- bit 8: flag A
- bit 9: flag B

The cycle select register bits are:
- bits [1:0]: access kind. 01 means instruction, 10 means operand, 11 means either.
- bits [3:2]: direction. 01 means read, 10 means write, 11 means either.
- bit 4: ignore the ID.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads 0, and no bus cycle produces a break request.
- R2: A channel whose access-kind field (cycle bits [1:0]) or direction field (bits [3:2]) is 00 never hits.
- R3: A channel hits only when `(busAddr & ~mask) == (addr & ~mask)`. The ID must also be equal unless cycle bit 4 is set.
- R4: A hit also requires `busIsInstr` to be enabled by the access-kind field (01 instruction, 10 operand) and `busWrite` to be enabled by the direction field (01 read, 10 write).
- R5: When control bit 3 is set, a channel B operand access hits only if `(busData & ~dmask) == (data & ~dmask)`. When bit 3 is clear, the data is not compared.
- R6: In independent mode (control bit 0 = 0), a hit on either channel sets that channel's flag (control bit 8 for A, bit 9 for B). It also pulses `brkReq` high for exactly the one clock after the hitting cycle.
- R7: While `blockExc` is 1, a hit still sets the flag, but `brkReq` stays low.
- R8: Hardware never clears the flags. A control write clears each flag whose written bit is 0. Writing 1 to a flag bit does not set it.
- R9: In sequential mode, a channel A hit only arms the unit and sets no flag. A later channel B hit raises `brkReq` and sets only flag B, and it consumes the arming. A channel B hit without arming does nothing.
- R10: In sequential mode, a cycle where A and B both hit only arms the unit. It raises no break.
- R11: Writing 0 to control bit 0 discards a pending arming.
- R12: `brkPre` goes high together with `brkReq` when the hit was an instruction fetch and the winning channel's pre-execution bit (control bit 1 for A, bit 2 for B) is set. Otherwise `brkPre` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busValid | input | 1 | A bus cycle is present |
| busAddr | input | 32 | Bus address |
| busAsid | input | 8 | Address-space ID of the cycle |
| busIsInstr | input | 1 | 1 = instruction fetch, 0 = operand access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busData | input | 32 | Operand data value |
| blockExc | input | 1 | Exceptions blocked |
| brkReq | output | 1 | Break request pulse |
| brkPre | output | 1 | Break is taken before execution |

## Verification
The bench builds the unit with its default widths: 32-bit address and data, and an 8-bit ID. At these widths, an address that differs only in masked low bits, or only in an unmasked bit, is easy to pick. So is a data value that differs only under the data mask, or an ID that differs while the ignore bit toggles. The sequential cases reuse one address on both channels. This makes the same-cycle A-and-B hit, the later B-only hit, and the arming discarded by a control write all reachable with a handful of cycles.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NCH   = 2;
  localparam int REG_W = 32;
  localparam int RA_W  = 4;

  localparam logic [RA_W-1:0] REG_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] REG_ADDRA = 4'd1;
  localparam logic [RA_W-1:0] REG_MASKA = 4'd2;
  localparam logic [RA_W-1:0] REG_ASIDA = 4'd3;
  localparam logic [RA_W-1:0] REG_CYCA  = 4'd4;
  localparam logic [RA_W-1:0] REG_ADDRB = 4'd5;
  localparam logic [RA_W-1:0] REG_MASKB = 4'd6;
  localparam logic [RA_W-1:0] REG_ASIDB = 4'd7;
  localparam logic [RA_W-1:0] REG_CYCB  = 4'd8;
  localparam logic [RA_W-1:0] REG_DATAB = 4'd9;
  localparam logic [RA_W-1:0] REG_DMASK = 4'd10;

  localparam int CYC_W = 5;

  // write strobes from control to datapath, one bit per channel where repeated
  typedef struct packed {
    logic [NCH-1:0] addr;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] asid;
    logic [NCH-1:0] cyc;
    logic           data;
    logic           dmask;
  } regWr_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  regWr_t           wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [RA_W-1:0]  rdAddr,
  output logic [REG_W-1:0] rdData,
  input  logic             dataEn,
  input  logic             busValid,
  input  logic [AW-1:0]    busAddr,
  input  logic [IW-1:0]    busAsid,
  input  logic             busIsInstr,
  input  logic             busWrite,
  input  logic [DW-1:0]    busData,
  output logic [NCH-1:0]   hit
);
  logic [AW-1:0]    addrR [NCH];
  logic [AW-1:0]    maskR [NCH];
  logic [IW-1:0]    asidR [NCH];
  logic [CYC_W-1:0] cycR  [NCH];
  logic [DW-1:0]    dataR;
  logic [DW-1:0]    dmaskR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR  <= '0;
      dmaskR <= '0;
    end else begin
      if (wr.data)  dataR  <= wdata[DW-1:0];
      if (wr.dmask) dmaskR <= wdata[DW-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic kindOk, dirOk, addrOk, idOk, dataOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrR[ch] <= '0;
        maskR[ch] <= '0;
        asidR[ch] <= '0;
        cycR[ch]  <= '0;
      end else begin
        if (wr.addr[ch]) addrR[ch] <= wdata[AW-1:0];
        if (wr.mask[ch]) maskR[ch] <= wdata[AW-1:0];
        if (wr.asid[ch]) asidR[ch] <= wdata[IW-1:0];
        if (wr.cyc[ch])  cycR[ch]  <= wdata[CYC_W-1:0];
      end
    end

    assign kindOk = busIsInstr ? cycR[ch][0] : cycR[ch][1];
    assign dirOk  = busWrite ? cycR[ch][3] : cycR[ch][2];
    assign addrOk = ((busAddr ^ addrR[ch]) & ~maskR[ch]) == '0;
    assign idOk   = cycR[ch][4] || (busAsid == asidR[ch]);

    if (ch == NCH - 1) begin : g_data
      assign dataOk = !(dataEn && !busIsInstr) || (((busData ^ dataR) & ~dmaskR) == '0);
    end else begin : g_nodata
      assign dataOk = 1'b1;
    end

    assign hit[ch] = busValid && kindOk && dirOk && addrOk && idOk && dataOk;

    p_chan_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      (cycR[ch][1:0] == 2'b00 || cycR[ch][3:2] == 2'b00) |-> !hit[ch]);
  end

  p_idle_bus_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (hit == '0));

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_ADDRA: rdData = REG_W'(addrR[0]);
      REG_MASKA: rdData = REG_W'(maskR[0]);
      REG_ASIDA: rdData = REG_W'(asidR[0]);
      REG_CYCA:  rdData = REG_W'(cycR[0]);
      REG_ADDRB: rdData = REG_W'(addrR[1]);
      REG_MASKB: rdData = REG_W'(maskR[1]);
      REG_ASIDB: rdData = REG_W'(asidR[1]);
      REG_CYCB:  rdData = REG_W'(cycR[1]);
      REG_DATAB: rdData = REG_W'(dataR);
      REG_DMASK: rdData = REG_W'(dmaskR);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NCH-1:0]   hit,
  input  logic             busIsInstr,
  input  logic             blockExc,
  output regWr_t           wr,
  output logic             dataEn,
  output logic [REG_W-1:0] ctrlRd,
  output logic             brkReq,
  output logic             brkPre
);
  logic seqR, preAR, preBR, flagA, flagB, armed;
  logic ctrlWr, hitA, hitB, seqDone, setA, setB, fire;

  always_comb begin
    wr       = '0;
    wr.addr  = {regWe && regAddr == REG_ADDRB, regWe && regAddr == REG_ADDRA};
    wr.mask  = {regWe && regAddr == REG_MASKB, regWe && regAddr == REG_MASKA};
    wr.asid  = {regWe && regAddr == REG_ASIDB, regWe && regAddr == REG_ASIDA};
    wr.cyc   = {regWe && regAddr == REG_CYCB,  regWe && regAddr == REG_CYCA};
    wr.data  = regWe && regAddr == REG_DATAB;
    wr.dmask = regWe && regAddr == REG_DMASK;
  end

  assign ctrlWr  = regWe && regAddr == REG_CTRL;
  assign hitA    = hit[0];
  assign hitB    = hit[1];
  assign seqDone = seqR && armed && hitB && !hitA;
  assign setA    = !seqR && hitA;
  assign setB    = seqR ? seqDone : hitB;
  assign fire    = setA || setB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqR   <= 1'b0;
      preAR  <= 1'b0;
      preBR  <= 1'b0;
      dataEn <= 1'b0;
      flagA  <= 1'b0;
      flagB  <= 1'b0;
      armed  <= 1'b0;
      brkReq <= 1'b0;
      brkPre <= 1'b0;
    end else begin
      if (ctrlWr) begin
        seqR   <= wdata[0];
        preAR  <= wdata[1];
        preBR  <= wdata[2];
        dataEn <= wdata[3];
      end
      flagA <= (ctrlWr ? (flagA && wdata[8]) : flagA) || setA;
      flagB <= (ctrlWr ? (flagB && wdata[9]) : flagB) || setB;
      if (ctrlWr && !wdata[0])   armed <= 1'b0;
      else if (seqR && hitA)     armed <= 1'b1;
      else if (seqDone)          armed <= 1'b0;
      brkReq <= fire && !blockExc;
      brkPre <= fire && !blockExc && busIsInstr && (setA ? preAR : preBR);
    end
  end

  assign ctrlRd = {22'd0, flagB, flagA, 4'd0, dataEn, preBR, preAR, seqR};

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    blockExc |=> !brkReq);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagA && !ctrlWr) |=> flagA);
  p_seq_no_flaga_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagA) |-> !$past(seqR));
  p_seq_unarmed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqR && !armed) |=> !brkReq);
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seqR && hitA) |=> !brkReq);
  p_pre_with_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    brkPre |-> brkReq);
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             busValid,
  input  logic [AW-1:0]    busAddr,
  input  logic [IW-1:0]    busAsid,
  input  logic             busIsInstr,
  input  logic             busWrite,
  input  logic [DW-1:0]    busData,
  input  logic             blockExc,
  output logic             brkReq,
  output logic             brkPre
);
  regWr_t           wr;
  logic             dataEn;
  logic [NCH-1:0]   hit;
  logic [REG_W-1:0] ctrlRd, dpRd;

  brk_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .wdata(regWdata),
    .hit(hit), .busIsInstr(busIsInstr), .blockExc(blockExc), .wr(wr),
    .dataEn(dataEn), .ctrlRd(ctrlRd), .brkReq(brkReq), .brkPre(brkPre)
  );

  brk_datapath #(.AW(AW), .DW(DW), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .wr(wr), .wdata(regWdata), .rdAddr(regAddr),
    .rdData(dpRd), .dataEn(dataEn), .busValid(busValid), .busAddr(busAddr),
    .busAsid(busAsid), .busIsInstr(busIsInstr), .busWrite(busWrite),
    .busData(busData), .hit(hit)
  );

  assign regRdata = (regAddr == REG_CTRL) ? ctrlRd : dpRd;
endmodule

// File: tb/tb_brk_unit.sv
`timescale 1ns/1ps
module tb_brk_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [7:0]  busAsid = '0;
  logic        busIsInstr = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busData = '0;
  logic        blockExc = 1'b0;
  logic        brkReq, brkPre;

  int total = 0;
  int bad = 0;
  logic [1:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  brk_unit dut (.*);

  // monitor: one expected item per bus cycle, seen just after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() != 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if ({brkReq, brkPre} !== e) begin
        bad++;
        $display("FAIL %s: req/pre actual=%b%b expected=%b", t, brkReq, brkPre, e);
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b0; regWe = 1'b1; regAddr = a; regWdata = d;
    expQ.push_back(2'b00); tagQ.push_back("R6 idle during write");
  endtask

  task automatic regCheck(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busValid = 1'b0; regWe = 1'b0; regAddr = a;
    expQ.push_back(2'b00); tagQ.push_back(tag);
    #1;
    total++;
    if (regRdata !== exp) begin
      bad++;
      $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, regRdata, exp);
    end
  endtask

  task automatic busCyc(input logic instr, input logic wrt, input logic [31:0] a,
                        input logic [7:0] id, input logic [31:0] d, input logic blk,
                        input logic expReq, input logic expPre, input string tag);
    @(negedge clk);
    regWe = 1'b0; busValid = 1'b1; busIsInstr = instr; busWrite = wrt;
    busAddr = a; busAsid = id; busData = d; blockExc = blk;
    expQ.push_back({expReq, expPre}); tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    regWe = 1'b0; busValid = 1'b0; blockExc = 1'b0;
    expQ.push_back(2'b00); tagQ.push_back("idle");
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regCheck(4'd0, 32'h0, "R1 ctrl after reset");
    regCheck(4'd1, 32'h0, "R1 addrA after reset");
    regCheck(4'd8, 32'h0, "R1 cycB after reset");
    busCyc(1, 0, 32'h0, 8'h0, 32'h0, 0, 0, 0, "R1 no break after reset");
    // channel A: instr read, addr 0x1000 mask 0xF, id 5
    regWrite(4'd1, 32'h1000);
    regWrite(4'd2, 32'hF);
    regWrite(4'd3, 32'h5);
    regWrite(4'd4, 32'h05);
    busCyc(1, 0, 32'h1003, 8'h5, 32'h0, 0, 1, 0, "R3 R6 masked hit");
    idle();
    regCheck(4'd0, 32'h100, "R6 flag A set");
    busCyc(1, 0, 32'h1013, 8'h5, 32'h0, 0, 0, 0, "R3 unmasked bit differs");
    busCyc(1, 0, 32'h1000, 8'h6, 32'h0, 0, 0, 0, "R3 id differs");
    regWrite(4'd4, 32'h15);
    busCyc(1, 0, 32'h1000, 8'h6, 32'h0, 0, 1, 0, "R3 id ignored");
    busCyc(0, 0, 32'h1000, 8'h6, 32'h0, 0, 0, 0, "R4 operand not selected");
    busCyc(1, 1, 32'h1000, 8'h6, 32'h0, 0, 0, 0, "R4 write not selected");
    // R2 kind field 00
    regWrite(4'd4, 32'h14);
    busCyc(1, 0, 32'h1000, 8'h6, 32'h0, 0, 0, 0, "R2 kind 00 disables");
    regWrite(4'd4, 32'h13);
    busCyc(1, 0, 32'h1000, 8'h6, 32'h0, 0, 0, 0, "R2 dir 00 disables");
    regWrite(4'd4, 32'h15);
    // R8 clear and write-1
    regWrite(4'd0, 32'h0);
    regCheck(4'd0, 32'h0, "R8 flags cleared by 0");
    regWrite(4'd0, 32'h300);
    regCheck(4'd0, 32'h0, "R8 writing 1 does not set");
    // channel B: operand write 0x2000, id ignored, data compare
    regWrite(4'd5, 32'h2000);
    regWrite(4'd6, 32'h0);
    regWrite(4'd8, 32'h1A);
    regWrite(4'd9, 32'hCAFE0000);
    regWrite(4'd10, 32'h0000FFFF);
    regWrite(4'd0, 32'h8);
    busCyc(0, 1, 32'h2000, 8'h9, 32'hCAFE1234, 0, 1, 0, "R5 data match under mask");
    busCyc(0, 1, 32'h2000, 8'h9, 32'hBEEF0000, 0, 0, 0, "R5 data mismatch");
    idle();
    regCheck(4'd0, 32'h208, "R6 flag B set");
    regWrite(4'd0, 32'h0);
    busCyc(0, 1, 32'h2000, 8'h9, 32'hBEEF0000, 0, 1, 0, "R5 data compare off");
    // R7 blocked
    regWrite(4'd0, 32'h0);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 1, 0, 0, "R7 blocked no request");
    idle();
    regCheck(4'd0, 32'h100, "R7 flag still set");
    // R12 pre-execution
    regWrite(4'd0, 32'h2);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 0, 1, 1, "R12 pre set");
    regWrite(4'd0, 32'h0);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 0, 1, 0, "R12 pre clear");
    // R9 sequential
    regWrite(4'd0, 32'h1);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 0, 0, 0, "R9 A only arms");
    idle();
    regCheck(4'd0, 32'h1, "R9 no flag from A");
    busCyc(0, 1, 32'h2000, 8'h1, 32'h0, 0, 1, 0, "R9 B completes");
    idle();
    regCheck(4'd0, 32'h201, "R9 only flag B");
    busCyc(0, 1, 32'h2000, 8'h1, 32'h0, 0, 0, 0, "R9 arming consumed");
    // R10 same cycle
    regWrite(4'd0, 32'h1);
    regWrite(4'd5, 32'h1000);
    regWrite(4'd8, 32'h1F);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 0, 0, 0, "R10 both hit only arms");
    idle();
    regCheck(4'd0, 32'h1, "R10 no flags");
    busCyc(0, 0, 32'h1000, 8'h1, 32'h0, 0, 1, 0, "R10 later B completes");
    // R11 discard arming
    regWrite(4'd0, 32'h1);
    busCyc(1, 0, 32'h1000, 8'h1, 32'h0, 0, 0, 0, "R11 arm");
    regWrite(4'd0, 32'h0);
    regWrite(4'd0, 32'h1);
    busCyc(0, 0, 32'h1000, 8'h1, 32'h0, 0, 0, 0, "R11 arming discarded");
    idle();
    regCheck(4'd0, 32'h1, "R11 no flag B");
    idle();
    idle();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule